// File: doc/BRIEF.md
# TCP Opening Handshake Tracker

This block follows one TCP connection by observing already-parsed segment headers, one segment per strobe. It checks that the three-way opening exchange happens in the order the protocol requires. The client must open with a SYN. The server must answer with a SYN+ACK that acknowledges the client's initial sequence number plus one. The client must then send a plain ACK that acknowledges the server's initial sequence number plus one. Only after that final ACK does the block report the connection as open for payload traffic.

Any segment that does not match the step the protocol expects next produces a one-cycle alert pulse, and the tracker falls back to its idle state. A reset segment from either side closes the tracker quietly. The sequence number and advertised window of each opening SYN are captured. They are presented with a valid flag while the connection is open, so that downstream sequence-window filters can bound the accepted byte ranges.

Top module: `tcp_hs_tracker`

## Requirements
- R1: After reset, `hs_open`, `alert` and `isn_valid` are 0, and all four captured outputs read 0.
- R2: While `seg_valid` is 0, no other input has any effect: state and outputs hold, and `alert` stays 0.
- R3: In the idle state, a segment with `seg_dir`=0 (client to server), SYN=1 and ACK=0 moves to the SYN-seen state and captures `seq_num` and `win` as the client's ISN and window. Any other non-RST segment in the idle state raises the alert and stays idle.
- R4: In the SYN-seen state, a segment with `seg_dir`=1, SYN=1, ACK=1 and `ack_num` = client ISN + 1 (mod 2^32) moves to the SYN+ACK-seen state and captures the server's ISN and window. Any other non-RST segment raises the alert and returns to idle.
- R5: In the SYN+ACK-seen state, a segment with `seg_dir`=0, SYN=0, ACK=1 and `ack_num` = server ISN + 1 (mod 2^32) opens the connection. Any other non-RST segment raises the alert and returns to idle.
- R6: While open, a segment carrying SYN raises the alert and returns to idle. Every other non-RST segment, including FIN and data, is accepted with no alert.
- R7: A segment with RST=1 returns the tracker to idle from any state with no alert, even when other flags are set.
- R8: `alert` is a registered pulse, high in the cycle after the offending strobe for exactly one cycle per offending segment.
- R9: `hs_open` and `isn_valid` are 1 exactly while the connection is open. Only then do `cli_isn`, `srv_isn`, `cli_win` and `srv_win` show the captured values; otherwise they read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seg_valid | input | 1 | One segment header is present this cycle |
| seg_dir | input | 1 | 0 = client to server, 1 = server to client |
| flag_syn | input | 1 | SYN flag |
| flag_ack | input | 1 | ACK flag |
| flag_rst | input | 1 | RST flag |
| flag_fin | input | 1 | FIN flag |
| seq_num | input | SEQ_W | Sequence number |
| ack_num | input | SEQ_W | Acknowledgement number |
| win | input | WIN_W | Advertised window |
| hs_open | output | 1 | Handshake completed, connection open |
| alert | output | 1 | One-cycle pulse for an out-of-order segment |
| isn_valid | output | 1 | Captured ISNs and windows are valid |
| cli_isn | output | SEQ_W | Client initial sequence number |
| srv_isn | output | SEQ_W | Server initial sequence number |
| cli_win | output | WIN_W | Client advertised window at SYN |
| srv_win | output | WIN_W | Server advertised window at SYN+ACK |

## Verification
The bench targets the acknowledgement arithmetic at the wrap point: an ISN of all ones must be acknowledged with zero. A design that compares without modulo behaviour, or that compares against the ISN rather than ISN + 1, would alert on a legal handshake or open on an illegal one. It sends RST together with SYN or ACK in every state; a design that ranks RST below the other flags would raise a spurious alert or move forward. It also sends SYN and wrong-direction segments while open, and drives random headers while the strobe is low. Designs that ignore these cases would either keep an attacked connection open or move state on idle bus values.

// File: rtl/tcp_hs_tracker.sv
module tcp_hs_tracker #(
  parameter int SEQ_W = 32,
  parameter int WIN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seg_valid,
  input  logic             seg_dir,
  input  logic             flag_syn,
  input  logic             flag_ack,
  input  logic             flag_rst,
  input  logic             flag_fin,
  input  logic [SEQ_W-1:0] seq_num,
  input  logic [SEQ_W-1:0] ack_num,
  input  logic [WIN_W-1:0] win,
  output logic             hs_open,
  output logic             alert,
  output logic             isn_valid,
  output logic [SEQ_W-1:0] cli_isn,
  output logic [SEQ_W-1:0] srv_isn,
  output logic [WIN_W-1:0] cli_win,
  output logic [WIN_W-1:0] srv_win
);

  typedef enum logic [1:0] {ST_IDLE, ST_SYN, ST_SYNACK, ST_OPEN} st_t;

  st_t              st, st_n;
  logic             alert_n, cap_c, cap_s;
  logic [SEQ_W-1:0] c_isn, s_isn;
  logic [WIN_W-1:0] c_win, s_win;

  wire from_cli = !seg_dir;
  wire c_ack_ok = (ack_num == c_isn + SEQ_W'(1));
  wire s_ack_ok = (ack_num == s_isn + SEQ_W'(1));

  always_comb begin
    st_n    = st;
    alert_n = 1'b0;
    cap_c   = 1'b0;
    cap_s   = 1'b0;
    if (seg_valid) begin
      if (flag_rst) begin
        st_n = ST_IDLE;
      end else begin
        unique case (st)
          ST_IDLE:
            if (from_cli && flag_syn && !flag_ack) begin
              st_n  = ST_SYN;
              cap_c = 1'b1;
            end else begin
              alert_n = 1'b1;
            end
          ST_SYN:
            if (!from_cli && flag_syn && flag_ack && c_ack_ok) begin
              st_n  = ST_SYNACK;
              cap_s = 1'b1;
            end else begin
              alert_n = 1'b1;
              st_n    = ST_IDLE;
            end
          ST_SYNACK:
            if (from_cli && !flag_syn && flag_ack && s_ack_ok) begin
              st_n = ST_OPEN;
            end else begin
              alert_n = 1'b1;
              st_n    = ST_IDLE;
            end
          ST_OPEN:
            if (flag_syn) begin
              alert_n = 1'b1;
              st_n    = ST_IDLE;
            end
          default: st_n = ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      alert <= 1'b0;
      c_isn <= '0;
      s_isn <= '0;
      c_win <= '0;
      s_win <= '0;
    end else begin
      st    <= st_n;
      alert <= alert_n;
      if (cap_c) begin
        c_isn <= seq_num;
        c_win <= win;
      end
      if (cap_s) begin
        s_isn <= seq_num;
        s_win <= win;
      end
    end
  end

  assign hs_open   = (st == ST_OPEN);
  assign isn_valid = hs_open;
  assign cli_isn   = isn_valid ? c_isn : '0;
  assign srv_isn   = isn_valid ? s_isn : '0;
  assign cli_win   = isn_valid ? c_win : '0;
  assign srv_win   = isn_valid ? s_win : '0;

  logic unused_fin;
  assign unused_fin = flag_fin;

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !seg_valid |=> $stable(st) && !alert); // R2
  AST_RST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid && flag_rst |=> !alert && st == ST_IDLE); // R7
  AST_ALERT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    alert |-> $past(seg_valid) && !$past(flag_rst)); // R8
  AST_OPEN_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_open) |-> $past(st) == ST_SYNACK && !$past(seg_dir)); // R5
  AST_SYNACK_BAD_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid && !flag_rst && st == ST_SYN && ack_num != c_isn + SEQ_W'(1)
    |=> alert && st == ST_IDLE); // R4
  AST_OPEN_SYN: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid && !flag_rst && flag_syn && st == ST_OPEN |=> alert && !hs_open); // R6
  AST_ISN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    hs_open && $past(hs_open) |-> $stable(cli_isn) && $stable(srv_isn)); // R9

endmodule

// File: tb/tb_tcp_hs_tracker.sv
module tb_tcp_hs_tracker;
  logic        clk = 0, rst_n = 0;
  logic        seg_valid = 0, seg_dir = 0, flag_syn = 0, flag_ack = 0, flag_rst = 0, flag_fin = 0;
  logic [31:0] seq_num = 0, ack_num = 0;
  logic [15:0] win = 0;
  logic        hs_open, alert, isn_valid;
  logic [31:0] cli_isn, srv_isn;
  logic [15:0] cli_win, srv_win;

  int checks = 0, failures = 0;
  int m_st = 0;
  bit m_alert = 0;
  logic [31:0] m_cisn = 0, m_sisn = 0;
  logic [15:0] m_cwin = 0, m_swin = 0;

  always #2 clk = ~clk;

  tcp_hs_tracker dut (.*);

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic void model(bit d, bit s, bit a, bit r, logic [31:0] sq, logic [31:0] ak, logic [15:0] w);
    m_alert = 0;
    if (r) begin m_st = 0; return; end
    case (m_st)
      0: if (!d && s && !a) begin m_st = 1; m_cisn = sq; m_cwin = w; end else m_alert = 1;
      1: if (d && s && a && ak == m_cisn + 32'd1) begin m_st = 2; m_sisn = sq; m_swin = w; end
         else begin m_alert = 1; m_st = 0; end
      2: if (!d && !s && a && ak == m_sisn + 32'd1) m_st = 3;
         else begin m_alert = 1; m_st = 0; end
      default: if (s) begin m_alert = 1; m_st = 0; end
    endcase
  endfunction

  task automatic check_outs(string tag);
    bit o = (m_st == 3);
    chk({tag, " R9 open"}, 32'(hs_open), 32'(o));
    chk({tag, " R8 alert"}, 32'(alert), 32'(m_alert));
    chk({tag, " R9 valid"}, 32'(isn_valid), 32'(o));
    chk({tag, " R9 cli_isn"}, cli_isn, o ? m_cisn : 32'd0);
    chk({tag, " R9 srv_isn"}, srv_isn, o ? m_sisn : 32'd0);
    chk({tag, " R9 wins"}, {cli_win, srv_win}, o ? {m_cwin, m_swin} : 32'd0);
  endtask

  task automatic send(string tag, bit d, bit s, bit a, bit r, bit f,
                      logic [31:0] sq, logic [31:0] ak, logic [15:0] w);
    @(negedge clk);
    seg_valid = 1; seg_dir = d; flag_syn = s; flag_ack = a; flag_rst = r; flag_fin = f;
    seq_num = sq; ack_num = ak; win = w;
    model(d, s, a, r, sq, ak, w);
    @(negedge clk);
    seg_valid = 0;
    check_outs(tag);
    if (m_alert) begin
      m_alert = 0;
      @(negedge clk);
      chk({tag, " R8 pulse_width"}, 32'(alert), 32'd0);
    end
  endtask

  task automatic handshake(string tag, logic [31:0] ci, logic [31:0] si);
    send({tag, " R3 syn"}, 0, 1, 0, 0, 0, ci, 32'd0, 16'h1111);
    send({tag, " R4 synack"}, 1, 1, 1, 0, 0, si, ci + 32'd1, 16'h2222);
    send({tag, " R5 ack"}, 0, 0, 1, 0, 0, ci + 32'd1, si + 32'd1, 16'h3333);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_outs("R1 reset");

    handshake("basic", 32'h1000, 32'h8000);
    chk("R5 opened", 32'(hs_open), 32'd1);
    send("R6 data", 1, 0, 1, 0, 0, 32'h8001, 32'h1001, 16'h1);
    send("R6 fin", 0, 0, 1, 0, 1, 32'h1001, 32'h8001, 16'h1);
    // R2: random headers with the strobe low change nothing
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      seg_dir = 1'($urandom); flag_syn = 1; flag_rst = 1'($urandom);
      seq_num = $urandom; ack_num = $urandom;
    end
    @(negedge clk);
    check_outs("R2 idle_bus");
    send("R6 syn_open", 0, 1, 0, 0, 0, 32'h5, 32'h0, 16'h1);

    handshake("wrap", 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    chk("R5 wrap_open", 32'(hs_open), 32'd1);
    send("R7 rst_open", 1, 1, 1, 1, 0, 32'h0, 32'h0, 16'h0);

    send("R3 syn", 0, 1, 0, 0, 0, 32'h42, 32'h0, 16'h9);
    send("R4 bad_ack", 1, 1, 1, 0, 0, 32'h77, 32'h42, 16'h9);
    send("R3 not_syn", 1, 0, 1, 0, 0, 32'h1, 32'h1, 16'h1);
    send("R3 syn", 0, 1, 0, 0, 0, 32'h50, 32'h0, 16'h9);
    send("R4 synack", 1, 1, 1, 0, 0, 32'h90, 32'h51, 16'h9);
    send("R7 rst_synack", 0, 1, 1, 1, 0, 32'h0, 32'h0, 16'h0);
    send("R3 syn", 0, 1, 0, 0, 0, 32'h50, 32'h0, 16'h9);
    send("R4 synack", 1, 1, 1, 0, 0, 32'h90, 32'h51, 16'h9);
    send("R5 bad_ack", 0, 0, 1, 0, 0, 32'h51, 32'h90, 16'h9);
    send("R3 syn", 0, 1, 0, 0, 0, 32'h50, 32'h0, 16'h9);
    send("R4 wrong_dir", 0, 1, 1, 0, 0, 32'h90, 32'h51, 16'h9);

    for (int i = 0; i < 600; i++) begin
      bit d, s, a, r;
      logic [31:0] sq = $urandom, ak = $urandom;
      if ($urandom_range(3) != 0) begin
        r = ($urandom_range(15) == 0);
        case (m_st)
          0: begin d = 0; s = 1; a = 0; end
          1: begin d = 1; s = 1; a = 1; ak = m_cisn + 32'd1; end
          2: begin d = 0; s = 0; a = 1; ak = m_sisn + 32'd1; end
          default: begin d = 1'($urandom); s = ($urandom_range(7) == 0); a = 1; end
        endcase
        if ($urandom_range(9) == 0) ak = ak + 32'd1;
      end else begin
        d = 1'($urandom); s = 1'($urandom); a = 1'($urandom); r = ($urandom_range(7) == 0);
      end
      send("rand R3 R4 R5 R6 R7", d, s, a, r, 1'($urandom), sq, ak, 16'($urandom));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule